// File: doc/BRIEF.md
# Span-Programmable Serial DAC Front End

This block is the digital side of a current-output DAC whose output span is chosen by software. A host sends a serial frame on `sdi`, clocked by `sck` and framed by the active-low `csN` line. Each frame carries a 4-bit command and a 16-bit data word. When `csN` returns high, the command is carried out. It can write the input buffer, move the input buffer into the DAC buffer, write both buffers, or pick one of six spans and write both buffers. The DAC buffer drives `dacCode`, and the span drives `spanCode`.

The block runs on a fast system clock `clk`. It samples `sck`, `sdi` and `csN` on that clock and acts on their edges, so `sck` must stay low and high for at least four `clk` periods each. A 32-bit shift register feeds `sdo`, which lets several devices be chained on a shared `sck` and `csN`. The active-low `clrN` clears all state at once, whether or not the clock is running. A parameter sets 12-, 14- or 16-bit resolution.

Top module: `spandac_front`

## Requirements
- R1: While `csN` is low, each rising `sck` edge shifts `sdi` into the 32-bit shift register. While `csN` is high, `sck` edges leave the register unchanged.
- R2: The command is the four bits at shift positions 23..20, which are the first four bits of a 24-bit frame sent MSB first. The data word is the last 16 bits shifted. Positions 19..16 are ignored, and so are the 8 leading bits of a 32-bit frame.
- R3: `sdo` is the oldest shift-register stage. The bit shifted in at one `sck` rise appears on `sdo` after the 32nd rise, counting that rise as the first.
- R4: `dacCode` and `spanCode` change only after a rising edge of `csN`, and never while a frame is being shifted in.
- R5: Commands 1000 to 1101 set `spanCode` to the command's low three bits: 0 is 0..5 V, 1 is 0..10 V, 2 is ±5 V, 3 is ±10 V, 4 is ±2.5 V and 5 is −2.5..7.5 V. These commands also write the data word into both buffers.
- R6: Command 0000 writes the data word into the input buffer only. `dacCode` does not change.
- R7: Command 0001 copies the input buffer into the DAC buffer.
- R8: Command 0010 writes the data word into both buffers and keeps the current span.
- R9: Commands 0011 to 0111, 1110 and 1111 change neither buffer nor the span.
- R10: While `clrN` is low, without waiting for `clk`, the shift register, both buffers and the span are zero. A 0001 command right after a clear therefore gives `dacCode` = 0. A clear that overlaps a `csN` rise cancels that command, and the span stays at 0.
- R11: With resolution `RES`, `dacCode` is the upper `RES` bits of the data word, and the lower bits are ignored.
- R12: A frame of fewer than 24 bits is still decoded, from whatever the shift register holds when `csN` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| clrN | input | 1 | Active-low asynchronous clear |
| csN | input | 1 | Active-low frame select; its rising edge executes the command |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Oldest shift-register bit, for daisy chains |
| dacCode | output | RES | Active DAC code |
| spanCode | output | 3 | Selected output span, encoded as in R5 |

## Verification
The command decoder is tried with all sixteen command codes, each with four data words: all zeros, all ones, a mixed pattern and a word with only its end bits set. Every command frame is followed by an update frame, which brings the input buffer out. This separates commands that write only the input buffer from those that write both, and shows that reserved codes leave both buffers and the span alone. Frames alternate between 24 and 32 bits. The 32-bit frames put ones in their leading don't-care byte, and their bit-by-bit `sdo` trace proves the full 32-stage delay. Further cases cover `sck` toggling while `csN` is high, truncated frames, and a clear both on its own and overlapping a `csN` rise. A second instance at 12-bit resolution shows that the low data bits are dropped.

// File: rtl/spandac_pkg.sv
package spandac_pkg;

  localparam int SHIFT_W  = 32;
  localparam int DATA_W   = 16;
  localparam int CMD_W    = 4;
  localparam int CMD_LSB  = 20;
  localparam int SPAN_W   = 3;
  localparam logic [SPAN_W-1:0] SPAN_MAX = 3'd5;

  localparam logic [CMD_W-1:0] CMD_LOAD_IN   = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_UPDATE    = 4'b0001;
  localparam logic [CMD_W-1:0] CMD_LOAD_BOTH = 4'b0010;

  typedef struct packed {
    logic              shiftEn;
    logic              shiftBit;
    logic              loadIn;
    logic              loadDac;
    logic              copyIn;
    logic              setSpan;
    logic [SPAN_W-1:0] spanSel;
  } strobe_t;

endpackage

// File: rtl/spandac_sampler.sv
module spandac_sampler #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         clrN,
  input  logic [W-1:0] pins,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        cur[i]  <= RST_VAL[i];
        prev[i] <= RST_VAL[i];
      end else begin
        cur[i]  <= pins[i];
        prev[i] <= cur[i];
      end
    end
  end

endmodule

// File: rtl/spandac_ctrl.sv
module spandac_ctrl
  import spandac_pkg::*;
(
  input  logic             clk,
  input  logic             clrN,
  input  logic             csN,
  input  logic             sck,
  input  logic             sdi,
  input  logic [CMD_W-1:0] cmdField,
  output strobe_t          strb
);

  localparam int PIN_W = 3;
  localparam int CS_IX = 2;
  localparam int CK_IX = 1;
  localparam int DI_IX = 0;

  logic [PIN_W-1:0] pinCur, pinPrev;
  logic sckRise, csRise, csLow;

  // csN idles high, so its sampled copies reset high to avoid a phantom load.
  spandac_sampler #(.W(PIN_W), .RST_VAL(3'b100)) uSampler (
    .clk  (clk),
    .clrN (clrN),
    .pins ({csN, sck, sdi}),
    .cur  (pinCur),
    .prev (pinPrev)
  );

  assign sckRise = pinCur[CK_IX] & ~pinPrev[CK_IX];
  assign csRise  = pinCur[CS_IX] & ~pinPrev[CS_IX];
  assign csLow   = ~pinCur[CS_IX];

  always_comb begin
    strb          = '0;
    strb.shiftEn  = sckRise & csLow;
    strb.shiftBit = pinCur[DI_IX];
    if (csRise) begin
      case (cmdField)
        CMD_LOAD_IN: strb.loadIn = 1'b1;
        CMD_UPDATE:  strb.copyIn = 1'b1;
        CMD_LOAD_BOTH: begin
          strb.loadIn  = 1'b1;
          strb.loadDac = 1'b1;
        end
        default: begin
          if (cmdField[CMD_W-1] && (cmdField[SPAN_W-1:0] <= SPAN_MAX)) begin
            strb.loadIn  = 1'b1;
            strb.loadDac = 1'b1;
            strb.setSpan = 1'b1;
            strb.spanSel = cmdField[SPAN_W-1:0];
          end
        end
      endcase
    end
  end

  AST_EXEC_NOT_DURING_SHIFT: assert property (@(posedge clk) disable iff (!clrN)
    $onehot0({strb.shiftEn, (strb.loadIn | strb.loadDac | strb.copyIn)})); // R4
  AST_SPAN_SEL_LEGAL: assert property (@(posedge clk) disable iff (!clrN)
    strb.setSpan |-> (strb.spanSel <= SPAN_MAX)); // R5

endmodule

// File: rtl/spandac_datapath.sv
module spandac_datapath
  import spandac_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic              clk,
  input  logic              clrN,
  input  strobe_t           strb,
  output logic [CMD_W-1:0]  cmdField,
  output logic              sdo,
  output logic [RES-1:0]    dacCode,
  output logic [SPAN_W-1:0] spanCode
);

  logic [SHIFT_W-1:0] shiftReg;
  logic [RES-1:0]     inBuf, dacBuf;
  logic [SPAN_W-1:0]  spanReg;
  logic [DATA_W-1:0]  dataWord;
  logic [RES-1:0]     codeBits;

  assign cmdField = shiftReg[CMD_LSB +: CMD_W];
  assign dataWord = shiftReg[DATA_W-1:0];
  assign codeBits = dataWord[DATA_W-1 -: RES];
  assign sdo      = shiftReg[SHIFT_W-1];
  assign dacCode  = dacBuf;
  assign spanCode = spanReg;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[SHIFT_W-2:0], strb.shiftBit};
    end
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      inBuf   <= '0;
      dacBuf  <= '0;
      spanReg <= '0;
    end else begin
      if (strb.loadIn)  inBuf   <= codeBits;
      if (strb.loadDac) dacBuf  <= codeBits;
      else if (strb.copyIn) dacBuf <= inBuf;
      if (strb.setSpan) spanReg <= strb.spanSel;
    end
  end

  AST_IDLE_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!clrN)
    !strb.shiftEn |=> $stable(shiftReg)); // R1
  AST_SDO_ADVANCES: assert property (@(posedge clk) disable iff (!clrN)
    strb.shiftEn |=> (sdo == $past(shiftReg[SHIFT_W-2]))); // R3
  AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!clrN)
    !(strb.loadDac | strb.copyIn) |=> $stable(dacCode)); // R4
  AST_UPDATE_COPIES: assert property (@(posedge clk) disable iff (!clrN)
    strb.copyIn |=> (dacCode == $past(inBuf))); // R7
  AST_SPAN_HOLDS: assert property (@(posedge clk) disable iff (!clrN)
    !strb.setSpan |=> $stable(spanCode)); // R8
  AST_SPAN_RANGE: assert property (@(posedge clk) disable iff (!clrN)
    spanCode <= SPAN_MAX); // R5

endmodule

// File: rtl/spandac_front.sv
module spandac_front
  import spandac_pkg::*;
#(
  parameter int RES = 16
) (
  input  logic           clk,
  input  logic           clrN,
  input  logic           csN,
  input  logic           sck,
  input  logic           sdi,
  output logic           sdo,
  output logic [RES-1:0] dacCode,
  output logic [2:0]     spanCode
);

  strobe_t          strb;
  logic [CMD_W-1:0] cmdField;

  spandac_ctrl uCtrl (
    .clk      (clk),
    .clrN     (clrN),
    .csN      (csN),
    .sck      (sck),
    .sdi      (sdi),
    .cmdField (cmdField),
    .strb     (strb)
  );

  spandac_datapath #(.RES(RES)) uPath (
    .clk      (clk),
    .clrN     (clrN),
    .strb     (strb),
    .cmdField (cmdField),
    .sdo      (sdo),
    .dacCode  (dacCode),
    .spanCode (spanCode)
  );

endmodule

// File: tb/tb_spandac_front.sv
module tb_spandac_front;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clrN = 1'b0, csN = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo12;
  logic [15:0] dacCode;
  logic [11:0] dac12;
  logic [2:0]  spanCode, span12;

  spandac_front #(.RES(16)) dut (
    .clk(clk), .clrN(clrN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .dacCode(dacCode), .spanCode(spanCode));

  spandac_front #(.RES(12)) dut12 (
    .clk(clk), .clrN(clrN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo12), .dacCode(dac12), .spanCode(span12));

  int checks = 0, fails = 0;
  logic [31:0] mShift = '0;
  logic [15:0] mIn = '0, mDac = '0;
  logic [2:0]  mSpan = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelReset();
    mShift = '0; mIn = '0; mDac = '0; mSpan = '0;
  endtask

  task automatic modelExec();
    logic [3:0]  c;
    logic [15:0] d;
    c = mShift[23:20];
    d = mShift[15:0];
    if (c == 4'b0000) mIn = d;
    else if (c == 4'b0001) mDac = mIn;
    else if (c == 4'b0010) begin mIn = d; mDac = d; end
    else if (c[3] && c[2:0] <= 3'd5) begin mIn = d; mDac = d; mSpan = c[2:0]; end
  endtask

  task automatic checkOutputs(input string req);
    chk(dacCode == mDac, req, dacCode, mDac);
    chk(spanCode == mSpan, req, spanCode, mSpan);
    chk(dac12 == mDac[15:4], "R11 upper bits only", dac12, mDac[15:4]);
  endtask

  task automatic clockBit(input logic b);
    sdi = b;
    waitN(2);
    sck = 1'b1;
    waitN(4);
    sck = 1'b0;
    waitN(3);
    mShift = {mShift[30:0], b};
  endtask

  task automatic sendFrame(input logic [31:0] bits, input int n, input bit chkSdo,
                           input string sdoReq, input string req);
    csN = 1'b0;
    waitN(3);
    for (int i = n - 1; i >= 0; i--) begin
      clockBit(bits[i]);
      if (chkSdo) chk(sdo == mShift[31], sdoReq, sdo, mShift[31]);
    end
    chk(dacCode == mDac, "R4 held before load edge", dacCode, mDac);
    csN = 1'b1;
    waitN(5);
    modelExec();
    checkOutputs(req);
  endtask

  function automatic string reqOf(input logic [3:0] c);
    if (c == 4'b0000) return "R6 input buffer only";
    if (c == 4'b0001) return "R7 update copy";
    if (c == 4'b0010) return "R8 load both keep span";
    if (c[3] && c[2:0] <= 3'd5) return "R5 span load";
    return "R9 reserved no effect";
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pat [4];
    pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'hA5C3; pat[3] = 16'h8001;

    waitN(3);
    chk(dacCode == 16'h0, "R10 reset code", dacCode, 0);
    chk(spanCode == 3'd0, "R10 reset span", spanCode, 0);
    chk(sdo == 1'b0, "R10 reset shift", sdo, 0);
    clrN = 1'b1;
    waitN(4);

    // Sweep every command code against several data words
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 4; p++) begin
        logic [15:0] d;
        d = pat[p] ^ 16'(c * 16'h1111);
        if (p[0])
          sendFrame({8'hC3 ^ 8'(c), 4'(c), 4'hF, d}, 32, 1'b1, "R3 sdo delay", reqOf(4'(c)));
        else
          sendFrame({8'h00, 4'(c), 4'h6, d}, 24, 1'b0, "R3", reqOf(4'(c)));
        // Reveal the input buffer through an update command
        sendFrame({8'h00, 4'b0001, 4'h0, ~d}, 24, 1'b0, "R3", "R2 R7 input buffer view");
      end
    end

    // SCK toggling while deselected must not shift
    sdi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      waitN(2); sck = 1'b1; waitN(4); sck = 1'b0; waitN(2);
    end
    chk(sdo == mShift[31], "R1 ignored sck", sdo, mShift[31]);
    sendFrame({8'h5A, 4'b1011, 4'h0, 16'h1234}, 32, 1'b1, "R1 shift contents kept", "R5 span load");

    // Truncated frames
    sendFrame(32'h0000_0A5, 12, 1'b0, "R3", "R12 short frame");
    sendFrame(32'h0000_0081, 8, 1'b0, "R3", "R12 short frame");
    sendFrame(32'h0000_0002, 5, 1'b0, "R3", "R12 short frame");

    // Asynchronous clear between clock edges
    sendFrame({8'h00, 4'b1100, 4'h0, 16'hBEEF}, 24, 1'b0, "R3", "R5 span load");
    #1 clrN = 1'b0;
    #0.5;
    chk(dacCode == 16'h0, "R10 async code", dacCode, 0);
    chk(spanCode == 3'd0, "R10 async span", spanCode, 0);
    waitN(3);
    clrN = 1'b1;
    modelReset();
    waitN(3);
    sendFrame({8'h00, 4'b0001, 4'h0, 16'h7777}, 24, 1'b0, "R3", "R10 update after clear");

    // Clear overlapping the load edge cancels the command
    sendFrame({8'h00, 4'b1101, 4'h0, 16'h4321}, 24, 1'b0, "R3", "R5 span load");
    csN = 1'b0;
    waitN(3);
    for (int i = 23; i >= 0; i--) clockBit(logic'((32'hB0FFFF >> i) & 1));
    csN = 1'b1;
    clrN = 1'b0;
    waitN(5);
    clrN = 1'b1;
    modelReset();
    waitN(5);
    checkOutputs("R10 clear beats load");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule